// File: doc/BRIEF.md
# HDLC Receive Deframer with Address Filter

This block recovers HDLC frames from a serial bit stream. Each input bit is qualified by a bit enable, so one bit is taken per enabled clock. The block watches the line for opening and closing flags, go-ahead patterns and idle channel. Inside a frame it removes the zeros that the transmitter inserted, checks the 16-bit frame check sequence and applies minimum-length rules. Accepted frame bytes go to a receive FIFO write port, each with a two-bit status code.

When address filtering is on, the first one or two received bytes are compared with two software-loaded reference registers. Bit 0 of each reference register enables the compare for its byte. Bit 0 of the first received byte marks whether the address is one byte or two bytes long. A frame that fails the filter leaves no trace in the FIFO. The two FCS bytes are consumed by the block and never written. The last data byte carries the end status.

Status codes on `wr_stat`: 2'b01 first byte of a frame, 2'b00 middle byte, 2'b10 last byte of a good frame, 2'b11 last byte of a bad frame.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: Within a frame, a zero received right after five consecutive ones is discarded. Data bytes are assembled least significant bit first, so the first received bit lands in bit 0.
- R2: The pattern zero, six ones, zero is a flag. Its bits are never data. A single flag both ends the current frame and opens the next one.
- R3: `idle` is high while at least 15 consecutive ones have been received since reset or since the last zero, and it drops after the next received zero.
- R4: `goahead` pulses high for one clock after the sequence zero, exactly seven ones, zero is received.
- R5: A frame holding fewer than 25 bits between flags after zero removal produces no FIFO write.
- R6: A frame of 25 to 31 bits produces exactly two writes: its first byte with status 01, then its second byte with status 11.
- R7: A frame of 32 or more bits that passes the filter writes every byte except the final two (the FCS). The first written byte has status 01 and later ones 00. The last data byte has status 10 when the CRC register (reflected CRC-16, polynomial 0x8408, preset 0xFFFF) holds 0xF0B8 at the closing flag and the bit count is a multiple of eight.
- R8: If the residue differs from 0xF0B8, or the frame length is not a whole number of bytes, the last data byte is written with status 11.
- R9: Seven consecutive ones inside a frame abort it. If 32 or more bits had been taken, one write with status 11 carrying the oldest byte not yet written ends the frame; otherwise nothing is written. After an abort, bits are ignored until the next flag.
- R10: With `addr_chk_en` low every frame passes. With it high and `addr_ref0[0]` = 1, bits 7:1 of the first received byte must equal `addr_ref0[7:1]`. With `addr_ref0[0]` = 0 the first byte is not compared.
- R11: When bit 0 of the first received byte is 1 the address is one byte long and the second byte is not compared. When it is 0 and `addr_ref1[0]` = 1, bits 7:1 of the second byte must equal `addr_ref1[7:1]`.
- R12: A frame that fails the address filter produces no FIFO write at all.
- R13: While `rst_n` is low, `wr_en`, `idle` and `goahead` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Qualifies `rx_bit` for this clock |
| rx_bit | input | 1 | Serial receive data |
| addr_chk_en | input | 1 | Enables address filtering |
| addr_ref0 | input | 8 | First address reference; bit 0 enables its compare |
| addr_ref1 | input | 8 | Second address reference; bit 0 enables its compare |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | 8 | Byte to write |
| wr_stat | output | 2 | Status code of the byte |
| idle | output | 1 | Idle channel detected |
| goahead | output | 1 | One-clock go-ahead pulse |

## Verification
A wrong ones count or a slip in the flag hold line shows up first on `idle` and `goahead`, which the bench compares on every clock. It also shows up as a shifted or missing byte in the write stream once the next byte completes. A bad byte or frame counter shows up as extra, missing or wrongly coded writes. A bad filter decision shows up as a whole frame appearing or vanishing. The write stream is compared record by record after every scenario, so any error is caught within that scenario.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_MID   = 2'b00,
    ST_FIRST = 2'b01,
    ST_GOOD  = 2'b10,
    ST_BAD   = 2'b11
  } rx_stat_e;
endpackage

// File: rtl/hdlc_rx_destuff.sv
module hdlc_rx_destuff #(
  parameter int IDLE_ONES = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  output logic commit_v,
  output logic commit_bit,
  output logic flag_ev,
  output logic close_ev,
  output logic abort_ev,
  output logic idle,
  output logic goahead
);
  localparam int OW  = $clog2(IDLE_ONES + 1);
  localparam int PD  = 7;
  localparam int PCW = $clog2(PD + 1);

  logic [OW-1:0]  ones_q, ones_n;
  logic           in_frame_q, in_frame_n;
  logic [PD-1:0]  pend_q, pend_n;
  logic [PCW-1:0] pcnt_q, pcnt_n;
  logic           ga_q, ga_n;
  logic           is5, is6, is7, push;

  always_comb begin
    is5 = (ones_q == OW'(5));
    is6 = (ones_q == OW'(6));
    is7 = (ones_q == OW'(7));
    flag_ev  = bit_en && !rx_bit && is6;
    close_ev = flag_ev && in_frame_q;
    abort_ev = bit_en && rx_bit && is6 && in_frame_q;
    push     = bit_en && in_frame_q && (rx_bit ? !is6 : (ones_q < OW'(5)));
    commit_v   = push && (pcnt_q == PCW'(PD));
    commit_bit = pend_q[0];
    idle    = (ones_q == OW'(IDLE_ONES));
    goahead = ga_q;
  end

  always_comb begin
    ones_n     = ones_q;
    in_frame_n = in_frame_q;
    pend_n     = pend_q;
    pcnt_n     = pcnt_q;
    ga_n       = 1'b0;
    if (bit_en) begin
      if (rx_bit) begin
        if (ones_q != OW'(IDLE_ONES)) ones_n = ones_q + OW'(1);
      end else begin
        ones_n = '0;
        ga_n   = is7;
      end
    end
    if (push) begin
      pend_n = {rx_bit, pend_q[PD-1:1]};
      if (pcnt_q != PCW'(PD)) pcnt_n = pcnt_q + PCW'(1);
    end
    if (flag_ev) begin
      in_frame_n = 1'b1;
      pcnt_n     = '0;
    end
    if (abort_ev) begin
      in_frame_n = 1'b0;
      pcnt_n     = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q     <= '0;
      in_frame_q <= 1'b0;
      pend_q     <= '0;
      pcnt_q     <= '0;
      ga_q       <= 1'b0;
    end else begin
      ones_q     <= ones_n;
      in_frame_q <= in_frame_n;
      pend_q     <= pend_n;
      pcnt_q     <= pcnt_n;
      ga_q       <= ga_n;
    end
  end

  AST_GA_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    goahead |-> !idle); // R4
  AST_IDLE_RISE_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> $past(bit_en && rx_bit)); // R3
  AST_IDLE_FALL_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle) |-> $past(bit_en && !rx_bit)); // R3
endmodule

// File: rtl/hdlc_rx_crc16.sv
module hdlc_rx_crc16 #(
  parameter logic [15:0] POLY_REV = 16'h8408,
  parameter logic [15:0] PRESET   = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic        din,
  output logic [15:0] crc
);
  logic [15:0] crc_q, crc_n;
  logic        fb;

  always_comb begin
    fb    = crc_q[0] ^ din;
    crc_n = crc_q;
    if (clr) begin
      crc_n = PRESET;
    end else if (en) begin
      crc_n = (crc_q >> 1) ^ (fb ? POLY_REV : 16'h0000);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= PRESET;
    else        crc_q <= crc_n;
  end

  assign crc = crc_q;
endmodule

// File: rtl/hdlc_rx_addr_match.sv
module hdlc_rx_addr_match
  import hdlc_rx_pkg::*;
(
  input  logic              chk_en,
  input  logic [BYTE_W-1:0] ref0,
  input  logic [BYTE_W-1:0] ref1,
  input  logic [BYTE_W-1:0] rx0,
  input  logic [BYTE_W-1:0] rx1,
  output logic              pass
);
  logic hit0, hit1;

  always_comb begin
    hit0 = !ref0[0] || (rx0[BYTE_W-1:1] == ref0[BYTE_W-1:1]);
    hit1 = rx0[0] || !ref1[0] || (rx1[BYTE_W-1:1] == ref1[BYTE_W-1:1]);
    pass = !chk_en || (hit0 && hit1);
  end
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int          IDLE_ONES   = 15,
  parameter logic [15:0] CRC_RESIDUE = 16'hF0B8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              rx_bit,
  input  logic              addr_chk_en,
  input  logic [BYTE_W-1:0] addr_ref0,
  input  logic [BYTE_W-1:0] addr_ref1,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic [1:0]        wr_stat,
  output logic              idle,
  output logic              goahead
);
  localparam int BCW  = $clog2(BYTE_W);
  localparam int KW   = 3;
  localparam logic [KW-1:0] KMAX = KW'(4);

  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  logic        commit_v, commit_bit, flag_ev, close_ev, abort_ev;
  logic [15:0] crc;
  logic        pass, crc_ok;

  hdlc_rx_destuff #(.IDLE_ONES(IDLE_ONES)) i_destuff (
    .clk(clk), .rst_n(rst_sync_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .commit_v(commit_v), .commit_bit(commit_bit), .flag_ev(flag_ev),
    .close_ev(close_ev), .abort_ev(abort_ev), .idle(idle), .goahead(goahead)
  );

  hdlc_rx_crc16 i_crc (
    .clk(clk), .rst_n(rst_sync_n), .clr(flag_ev || abort_ev),
    .en(commit_v), .din(commit_bit), .crc(crc)
  );

  logic [BYTE_W-1:0] asm_q, asm_n, h0_q, h0_n, h1_q, h1_n, h2_q, h2_n;
  logic [BCW-1:0]    bcnt_q, bcnt_n;
  logic [KW-1:0]     kcnt_q, kcnt_n;
  logic              accept_q, accept_n;
  logic              pend_v_q, pend_v_n;
  logic [BYTE_W-1:0] pend_d_q, pend_d_n;
  logic              wr_en_q, wr_en_n;
  logic [BYTE_W-1:0] wr_data_q, wr_data_n;
  rx_stat_e          wr_stat_q, wr_stat_n;

  hdlc_rx_addr_match i_addr (
    .chk_en(addr_chk_en), .ref0(addr_ref0), .ref1(addr_ref1),
    .rx0(h0_q), .rx1(h1_q), .pass(pass)
  );

  assign crc_ok = (crc == CRC_RESIDUE);

  always_comb begin
    asm_n = asm_q;  bcnt_n = bcnt_q;  kcnt_n = kcnt_q;
    h0_n = h0_q;    h1_n = h1_q;      h2_n = h2_q;
    accept_n = accept_q;
    pend_v_n = 1'b0;  pend_d_n = pend_d_q;
    wr_en_n = 1'b0;   wr_data_n = wr_data_q;  wr_stat_n = wr_stat_q;

    if (pend_v_q) begin
      wr_en_n = 1'b1;  wr_data_n = pend_d_q;  wr_stat_n = ST_BAD;
    end

    if (commit_v) begin
      asm_n  = {commit_bit, asm_q[BYTE_W-1:1]};
      bcnt_n = bcnt_q + BCW'(1);
      if (bcnt_q == BCW'(BYTE_W - 1)) begin
        h0_n = h1_q;  h1_n = h2_q;  h2_n = {commit_bit, asm_q[BYTE_W-1:1]};
        if (kcnt_q != KMAX) kcnt_n = kcnt_q + KW'(1);
        if (kcnt_q == KW'(3)) begin
          accept_n = pass;
          if (pass) begin
            wr_en_n = 1'b1;  wr_data_n = h0_q;  wr_stat_n = ST_FIRST;
          end
        end else if (kcnt_q == KMAX && accept_q) begin
          wr_en_n = 1'b1;  wr_data_n = h0_q;  wr_stat_n = ST_MID;
        end
      end
    end

    if (close_ev) begin
      if (kcnt_q == KMAX) begin
        if (accept_q) begin
          wr_en_n   = 1'b1;
          wr_data_n = h0_q;
          wr_stat_n = (crc_ok && bcnt_q == '0) ? ST_GOOD : ST_BAD;
        end
      end else if (kcnt_q == KW'(3) && bcnt_q != '0 && pass) begin
        wr_en_n  = 1'b1;  wr_data_n = h0_q;  wr_stat_n = ST_FIRST;
        pend_v_n = 1'b1;  pend_d_n  = h1_q;
      end
    end

    if (abort_ev && kcnt_q == KMAX && accept_q) begin
      wr_en_n = 1'b1;  wr_data_n = h0_q;  wr_stat_n = ST_BAD;
    end

    if (flag_ev || abort_ev) begin
      bcnt_n = '0;  kcnt_n = '0;  accept_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      asm_q <= '0;  bcnt_q <= '0;  kcnt_q <= '0;
      h0_q <= '0;   h1_q <= '0;    h2_q <= '0;
      accept_q <= 1'b0;  pend_v_q <= 1'b0;  pend_d_q <= '0;
      wr_en_q <= 1'b0;   wr_data_q <= '0;   wr_stat_q <= ST_MID;
    end else begin
      asm_q <= asm_n;  bcnt_q <= bcnt_n;  kcnt_q <= kcnt_n;
      h0_q <= h0_n;    h1_q <= h1_n;      h2_q <= h2_n;
      accept_q <= accept_n;  pend_v_q <= pend_v_n;  pend_d_q <= pend_d_n;
      wr_en_q <= wr_en_n;    wr_data_q <= wr_data_n; wr_stat_q <= wr_stat_n;
    end
  end

  assign wr_en   = wr_en_q;
  assign wr_data = wr_data_q;
  assign wr_stat = wr_stat_q;

  logic open_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) open_q <= 1'b0;
    else if (wr_en_q && wr_stat_q == ST_FIRST) open_q <= 1'b1;
    else if (wr_en_q && wr_stat_q[1]) open_q <= 1'b0;
  end

  AST_FIRST_WHEN_CLOSED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en_q && wr_stat_q == ST_FIRST) |-> !open_q); // R7
  AST_MID_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en_q && wr_stat_q == ST_MID) |-> open_q); // R7
  AST_END_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en_q && wr_stat_q[1]) |-> open_q); // R6
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    idle |-> !wr_en_q); // R3
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!wr_en && !idle && !goahead)); // R13
endmodule

// File: tb/test_hdlc_rx_deframer.sv
module test_hdlc_rx_deframer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, bit_en, rx_bit, addr_chk_en;
  logic [7:0] addr_ref0, addr_ref1, wr_data;
  logic [1:0] wr_stat;
  logic       wr_en, idle, goahead;

  int  checks = 0, failures = 0;
  bit  done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_rx_deframer i_hdlc_rx_deframer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .addr_chk_en(addr_chk_en), .addr_ref0(addr_ref0), .addr_ref1(addr_ref1),
    .wr_en(wr_en), .wr_data(wr_data), .wr_stat(wr_stat),
    .idle(idle), .goahead(goahead)
  );

  // behavioural reference model state
  int   m_ones = 0;
  bit   m_in = 0;
  bit   fb[$];
  int   exp_q[$], exp_tag[$], act_q[$];
  bit   exp_idle = 0, exp_ga = 0;
  int   cur_req = 0;
  int   cmp_idx = 0;
  int   tx_ones = 0;
  logic [7:0] txq[$];

  function automatic logic [15:0] crc_bit(logic [15:0] c, bit b);
    logic f;
    f = c[0] ^ b;
    c = c >> 1;
    if (f) c = c ^ 16'h8408;
    return c;
  endfunction

  function automatic void push_exp(logic [7:0] d, logic [1:0] s);
    exp_q.push_back({22'd0, d, s});
    exp_tag.push_back(cur_req);
  endfunction

  function automatic void finish_frame(bit by_flag);
    int n, k;
    logic [7:0] by[$];
    logic [7:0] v;
    logic [15:0] c;
    bit pass, h0, h1;
    n = fb.size() - 7;
    if (n < 0) n = 0;
    k = n / 8;
    c = 16'hFFFF;
    for (int i = 0; i < n; i++) c = crc_bit(c, fb[i]);
    for (int j = 0; j < k; j++) begin
      for (int t = 0; t < 8; t++) v[t] = fb[8*j+t];
      by.push_back(v);
    end
    pass = 1;
    if (k >= 3 && addr_chk_en) begin
      h0 = !addr_ref0[0] || (by[0][7:1] == addr_ref0[7:1]);
      h1 = by[0][0] || !addr_ref1[0] || (by[1][7:1] == addr_ref1[7:1]);
      pass = h0 && h1;
    end
    if (!pass) return;
    if (by_flag) begin
      if (n < 25) return;
      if (n < 32) begin
        push_exp(by[0], 2'b01);
        push_exp(by[1], 2'b11);
        return;
      end
      for (int i = 0; i <= k - 4; i++) push_exp(by[i], (i == 0) ? 2'b01 : 2'b00);
      push_exp(by[k-3], (n % 8 == 0 && c == 16'hF0B8) ? 2'b10 : 2'b11);
    end else if (k >= 4) begin
      for (int i = 0; i <= k - 4; i++) push_exp(by[i], (i == 0) ? 2'b01 : 2'b00);
      push_exp(by[k-3], 2'b11);
    end
  endfunction

  function automatic void model_bit(bit b);
    exp_ga = 0;
    if (b) begin
      if (m_in && m_ones == 6) begin
        finish_frame(0);
        m_in = 0;
        fb.delete();
      end else if (m_in) begin
        fb.push_back(1'b1);
      end
      if (m_ones < 15) m_ones++;
    end else begin
      if (m_ones == 6) begin
        if (m_in) finish_frame(1);
        m_in = 1;
        fb.delete();
      end else if (m_ones == 7) begin
        exp_ga = 1;
      end else if (m_ones < 5 && m_in) begin
        fb.push_back(1'b0);
      end
      m_ones = 0;
    end
    exp_idle = (m_ones >= 15);
  endfunction

  task automatic fail_line(string req, int act, int exp);
    failures++;
    $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
  endtask

  task automatic step(input bit b, input bit en);
    @(negedge clk);
    checks++;
    if (idle !== exp_idle) fail_line("R3 idle", idle, exp_idle);
    checks++;
    if (goahead !== exp_ga) fail_line("R4 goahead", goahead, exp_ga);
    if (wr_en === 1'b1) act_q.push_back({22'd0, wr_data, wr_stat});
    exp_ga = 0;
    if (en) model_bit(b);
    rx_bit = b;
    bit_en = en;
  endtask

  task automatic send_flag();
    for (int i = 0; i < 8; i++) step(i != 0 && i != 7, 1'b1);
    tx_ones = 0;
  endtask

  task automatic send_stuffed(input bit b);
    step(b, 1'b1);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin
        step(1'b0, 1'b1); // R1 inserted zero
        tx_ones = 0;
      end
    end else begin
      tx_ones = 0;
    end
  endtask

  // mode 0: good FCS, 1: corrupted FCS, 2: no FCS; extra trailing bits 0,1,0...
  task automatic send_frame(input int mode, input int extra);
    logic [15:0] c;
    logic [15:0] f;
    c = 16'hFFFF;
    foreach (txq[i]) for (int t = 0; t < 8; t++) begin
      c = crc_bit(c, txq[i][t]);
      send_stuffed(txq[i][t]);
    end
    f = ~c;
    if (mode == 1) f = f ^ 16'h0010;
    if (mode != 2) for (int t = 0; t < 16; t++) send_stuffed(f[t]);
    for (int t = 0; t < extra; t++) send_stuffed(t[0]);
    send_flag();
  endtask

  task automatic check_stream(input int req);
    int hi;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
    hi = (exp_q.size() > act_q.size()) ? exp_q.size() : act_q.size();
    checks++;
    if (exp_q.size() != act_q.size())
      fail_line($sformatf("R%0d write count", req), act_q.size(), exp_q.size());
    for (int i = cmp_idx; i < hi; i++) begin
      checks++;
      if (i >= exp_q.size())
        fail_line($sformatf("R%0d extra write", req), act_q[i], 0);
      else if (i >= act_q.size())
        fail_line($sformatf("R%0d missing write", exp_tag[i]), 0, exp_q[i]);
      else if (act_q[i] != exp_q[i])
        fail_line($sformatf("R%0d write {data,stat}", exp_tag[i]), act_q[i], exp_q[i]);
    end
    cmp_idx = hi;
    while (exp_q.size() < hi) begin exp_q.push_back(-1); exp_tag.push_back(req); end
    while (act_q.size() < hi) act_q.push_back(-2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL R13 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; rx_bit = 1'b1;
    addr_chk_en = 1'b0; addr_ref0 = 8'h00; addr_ref1 = 8'h00;
    repeat (3) @(negedge clk);
    checks++; // R13 reset state
    if (wr_en !== 1'b0 || idle !== 1'b0 || goahead !== 1'b0)
      fail_line("R13 reset outputs", {wr_en, idle, goahead}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);

    send_flag();
    // R7 good frame, filter off; R2 frames separated by one flag
    cur_req = 7; txq = '{8'h21, 8'h5A, 8'hC3}; send_frame(0, 0);
    cur_req = 2; txq = '{8'h10, 8'h99}; send_frame(0, 0);
    check_stream(7);
    // R1 data dense in ones forces zero insertion
    cur_req = 1; txq = '{8'hFF, 8'h7E, 8'h3F, 8'hF8, 8'hFE}; send_frame(0, 0);
    check_stream(1);
    // R8 corrupted FCS, then trailing bits that break byte alignment
    cur_req = 8; txq = '{8'h44, 8'h55, 8'h66}; send_frame(1, 0);
    txq = '{8'h12, 8'h34, 8'h56}; send_frame(0, 3);
    check_stream(8);
    // R5 24 bits between flags, and an empty frame
    cur_req = 5; txq = '{8'hA1, 8'hB2, 8'hC3}; send_frame(2, 0);
    send_flag();
    check_stream(5);
    // R6 27 bits
    cur_req = 6; txq = '{8'h81, 8'h42, 8'h24}; send_frame(2, 3);
    check_stream(6);
    // R9 abort after six bytes, then ignored bits, then a short aborted frame
    cur_req = 9;
    txq = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h00};
    foreach (txq[i]) for (int t = 0; t < 8; t++) send_stuffed(txq[i][t]);
    for (int i = 0; i < 7; i++) step(1'b1, 1'b1);
    for (int i = 0; i < 40; i++) step(i[1] ^ i[0], 1'b1);
    send_flag();
    txq = '{8'h0F};
    foreach (txq[i]) for (int t = 0; t < 8; t++) send_stuffed(txq[i][t]);
    for (int i = 0; i < 7; i++) step(1'b1, 1'b1);
    send_flag();
    txq = '{8'h33, 8'h44, 8'h55}; send_frame(0, 0);
    check_stream(9);
    // R3 idle channel, then R4 go-ahead
    cur_req = 3;
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
    send_flag();
    cur_req = 4;
    step(1'b0, 1'b1);
    for (int i = 0; i < 7; i++) step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    send_flag();
    check_stream(4);
    // R10 one-byte address match, R12 mismatch dropped
    addr_chk_en = 1'b1; addr_ref0 = {7'h12, 1'b1}; addr_ref1 = {7'h40, 1'b1};
    cur_req = 10; txq = '{{7'h12, 1'b1}, 8'h77, 8'h88}; send_frame(0, 0);
    cur_req = 12; txq = '{{7'h13, 1'b1}, 8'h77, 8'h88}; send_frame(0, 0);
    cur_req = 12; txq = '{{7'h13, 1'b1}, 8'h77, 8'h66}; send_frame(2, 3);
    check_stream(12);
    // R11 two-byte address
    cur_req = 11; txq = '{{7'h12, 1'b0}, {7'h40, 1'b0}, 8'h5C}; send_frame(0, 0);
    cur_req = 12; txq = '{{7'h12, 1'b0}, {7'h41, 1'b0}, 8'h5C}; send_frame(0, 0);
    cur_req = 11; txq = '{{7'h12, 1'b1}, {7'h41, 1'b0}, 8'h5C}; send_frame(0, 0);
    addr_ref1 = {7'h40, 1'b0};
    cur_req = 11; txq = '{{7'h12, 1'b0}, {7'h55, 1'b0}, 8'h5C}; send_frame(0, 0);
    check_stream(11);
    // R10 first-byte compare disabled
    addr_ref0 = {7'h12, 1'b0};
    cur_req = 10; txq = '{{7'h7F, 1'b1}, 8'h01, 8'h02, 8'h03}; send_frame(0, 0);
    addr_chk_en = 1'b0;
    cur_req = 10; txq = '{{7'h13, 1'b1}, 8'h09}; send_frame(0, 0);
    check_stream(10);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule